// File: doc/BRIEF.md
# Command and data byte FIFO

This block is the byte-wide FIFO register that a host sees on a storage bus controller. A control input selects where host writes go. While command collection is on, each written byte goes into a command buffer that keeps its own length count. Otherwise the byte goes into a transfer buffer, which has separate read and write pointers and a signed size count.

Host reads take bytes from the transfer buffer. When the phase input says data-out, a read returns zero and leaves the buffer as it is. When a read leaves the two pointers equal, both pointers go back to zero. An occupancy output always shows the write pointer minus the read pointer.

A status load puts a two-byte response into the transfer buffer. A flush empties both buffers. A dropped write sets a sticky overrun flag. The protocol sequencer above this block drives the mode, the phase and the strobes, and it reads the command bytes through a random-access port.

Top module: `cdfifo_top`

## Requirements
- R1: After reset, fifo_flags_o, xfer_size_o, cmd_len_o, overrun_o and fifo_rdata_o are all zero.
- R2: When cmd_collect_i is 1 and cmd_len_o is below CMD_DEPTH, a write stores the byte at index cmd_len_o and raises cmd_len_o by one. fifo_flags_o and xfer_size_o do not change. cmd_rd_data_o returns the byte stored at cmd_rd_addr_i.
- R3: When cmd_collect_i is 1 and cmd_len_o equals CMD_DEPTH, a write is dropped, cmd_len_o keeps its value and overrun_o becomes 1.
- R4: When cmd_collect_i is 0 and the write pointer is below DATA_DEPTH-1, a write stores the byte at the write pointer, advances the pointer and raises xfer_size_o by one.
- R5: When cmd_collect_i is 0 and the write pointer equals DATA_DEPTH-1, a write is dropped and overrun_o becomes 1. This holds even if earlier reads have left free entries below the read pointer.
- R6: A read while phase_i is zero (the data-out phase) makes fifo_rdata_o zero in the next cycle. It pops nothing.
- R7: A read while phase_i is nonzero and the read pointer is below the write pointer puts the byte at the read pointer on fifo_rdata_o in the next cycle. It advances the read pointer and lowers xfer_size_o by one. Bytes come out in the order they were written.
- R8: A read while phase_i is nonzero and the transfer buffer is empty leaves fifo_rdata_o, fifo_flags_o and xfer_size_o unchanged.
- R9: When a read leaves the read pointer equal to the write pointer, both pointers return to zero. After that, DATA_DEPTH-1 further writes are accepted.
- R10: status_load_i sets entry 0 to status_byte_i and entry 1 to zero. It sets the read pointer to 0, the write pointer to 2 and xfer_size_o to 2. It takes priority over a write or a read in the same cycle.
- R11: flush_i sets both transfer pointers, xfer_size_o and cmd_len_o to zero and clears overrun_o. It takes priority over status_load_i and over any access in the same cycle. fifo_rdata_o keeps its value.
- R12: overrun_o stays at 1 until a flush or a reset, even after later writes are accepted.
- R13: fifo_flags_o equals the write pointer minus the read pointer on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_wr_i | input | 1 | Host write strobe for the FIFO register |
| fifo_wdata_i | input | 8 | Byte being written |
| fifo_rd_i | input | 1 | Host read strobe for the FIFO register |
| fifo_rdata_o | output | 8 | Byte returned by the last read |
| cmd_collect_i | input | 1 | Sends writes to the command buffer |
| phase_i | input | PHASE_W | Bus phase; zero means data-out |
| flush_i | input | 1 | Empties both buffers and clears overrun |
| status_load_i | input | 1 | Loads the two-byte status response |
| status_byte_i | input | 8 | Status byte for the response |
| fifo_flags_o | output | clog2(DATA_DEPTH) | Write pointer minus read pointer |
| xfer_size_o | output | clog2(DATA_DEPTH)+2 | Signed transfer size count |
| cmd_len_o | output | clog2(CMD_DEPTH+1) | Number of command bytes collected |
| cmd_rd_addr_i | input | clog2(CMD_DEPTH) | Command buffer read index |
| cmd_rd_data_o | output | 8 | Command byte at cmd_rd_addr_i |
| overrun_o | output | 1 | Sticky flag for a dropped write |

## Verification
The transfer buffer is filled and drained at every fill level from one byte up to its limit. Each level uses a different byte pattern and a different nonzero phase, so a problem with ordering, size counting or rewind shows up at one particular occupancy. Writes are also made against a full buffer that is only partly drained, which separates an overrun test on the write pointer from one on occupancy. Command collection runs up to capacity and one byte past it, alongside data that is already held. This shows that the two buffers are kept apart and that overrun is detected separately in each. The bench also drives flush, status load and host access together in the same cycle, and tries data-out and empty reads, to settle priority and the cases where nothing should change.

// File: rtl/cdfifo_pkg.sv
package cdfifo_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_FLUSH,
    OP_STATUS,
    OP_ACCESS
  } op_e;
endpackage

// File: rtl/cdfifo_cmd_buf.sv
module cdfifo_cmd_buf
  import cdfifo_pkg::*;
#(
  parameter int CMD_DEPTH = 32,
  localparam int LW = $clog2(CMD_DEPTH + 1),
  localparam int AW = $clog2(CMD_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  byte_t         push_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o,
  output logic [LW-1:0] len_o,
  output logic          drop_o
);
  localparam logic [LW-1:0] FULL = LW'(CMD_DEPTH);

  byte_t         mem_q [CMD_DEPTH];
  logic [LW-1:0] len_q;
  logic          push_ok;

  assign push_ok   = push_i && (len_q != FULL);
  assign drop_o    = push_i && (len_q == FULL);
  assign len_o     = len_q;
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (clr_i) begin
      len_q <= '0;
    end else if (push_ok) begin
      len_q <= len_q + LW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CMD_DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok && !clr_i) begin
      mem_q[len_q[AW-1:0]] <= push_data_i;
    end
  end
endmodule

// File: rtl/cdfifo_data_buf.sv
module cdfifo_data_buf
  import cdfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int SW = PW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 stat_i,
  input  byte_t                stat_byte_i,
  input  logic                 wr_i,
  input  byte_t                wdata_i,
  input  logic                 rd_i,
  input  logic                 rd_zero_i,
  output byte_t                rdata_o,
  output logic [PW-1:0]        wr_ptr_o,
  output logic [PW-1:0]        rd_ptr_o,
  output logic signed [SW-1:0] size_o,
  output logic [PW-1:0]        flags_o,
  output logic                 drop_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  byte_t                mem_q [DEPTH];
  byte_t                rdata_q;
  logic [PW-1:0]        wr_q, rd_q, wr_nxt, rd_nxt;
  logic signed [SW-1:0] size_q, size_nxt;
  logic                 wr_ok, pop;

  always_comb begin
    wr_ok    = wr_i && (wr_q != LAST);
    drop_o   = wr_i && (wr_q == LAST);
    pop      = rd_i && !rd_zero_i && (rd_q < wr_q);
    wr_nxt   = wr_q + {{(PW-1){1'b0}}, wr_ok};
    rd_nxt   = rd_q + {{(PW-1){1'b0}}, pop};
    size_nxt = size_q + $signed({{(SW-1){1'b0}}, wr_ok})
                      - $signed({{(SW-1){1'b0}}, pop});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      size_q  <= '0;
      rdata_q <= '0;
    end else if (clr_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      size_q <= '0;
    end else if (stat_i) begin
      wr_q   <= PW'(2);
      rd_q   <= '0;
      size_q <= SW'(2);
    end else begin
      size_q <= size_nxt;
      if (rd_i && rd_zero_i) rdata_q <= '0;
      else if (pop)          rdata_q <= mem_q[rd_q];
      // rewind once the reader catches the writer
      if (rd_i && (rd_nxt == wr_nxt)) begin
        wr_q <= '0;
        rd_q <= '0;
      end else begin
        wr_q <= wr_nxt;
        rd_q <= rd_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (!clr_i) begin
      if (stat_i) begin
        mem_q[0] <= stat_byte_i;
        mem_q[1] <= '0;
      end else if (wr_ok) begin
        mem_q[wr_q] <= wdata_i;
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign size_o   = size_q;
  assign flags_o  = wr_q - rd_q;
endmodule

// File: rtl/cdfifo_top.sv
module cdfifo_top
  import cdfifo_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int PHASE_W    = 3,
  localparam int PW  = $clog2(DATA_DEPTH),
  localparam int SW  = PW + 2,
  localparam int LW  = $clog2(CMD_DEPTH + 1),
  localparam int CAW = $clog2(CMD_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fifo_wr_i,
  input  logic [7:0]           fifo_wdata_i,
  input  logic                 fifo_rd_i,
  output logic [7:0]           fifo_rdata_o,
  input  logic                 cmd_collect_i,
  input  logic [PHASE_W-1:0]   phase_i,
  input  logic                 flush_i,
  input  logic                 status_load_i,
  input  logic [7:0]           status_byte_i,
  output logic [PW-1:0]        fifo_flags_o,
  output logic signed [SW-1:0] xfer_size_o,
  output logic [LW-1:0]        cmd_len_o,
  input  logic [CAW-1:0]       cmd_rd_addr_i,
  output logic [7:0]           cmd_rd_data_o,
  output logic                 overrun_o
);
  op_e           op;
  logic          cmd_push, data_wr, data_rd;
  logic          cmd_drop, data_drop;
  logic          overrun_q;
  logic [PW-1:0] wr_ptr, rd_ptr;

  // flush beats status load beats host access
  always_comb begin
    if (flush_i)                     op = OP_FLUSH;
    else if (status_load_i)          op = OP_STATUS;
    else if (fifo_wr_i || fifo_rd_i) op = OP_ACCESS;
    else                             op = OP_IDLE;
  end

  assign cmd_push = (op == OP_ACCESS) && fifo_wr_i && cmd_collect_i;
  assign data_wr  = (op == OP_ACCESS) && fifo_wr_i && !cmd_collect_i;
  assign data_rd  = (op == OP_ACCESS) && fifo_rd_i;

  cdfifo_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (op == OP_FLUSH),
    .push_i      (cmd_push),
    .push_data_i (fifo_wdata_i),
    .rd_addr_i   (cmd_rd_addr_i),
    .rd_data_o   (cmd_rd_data_o),
    .len_o       (cmd_len_o),
    .drop_o      (cmd_drop)
  );

  cdfifo_data_buf #(.DEPTH(DATA_DEPTH)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (op == OP_FLUSH),
    .stat_i      (op == OP_STATUS),
    .stat_byte_i (status_byte_i),
    .wr_i        (data_wr),
    .wdata_i     (fifo_wdata_i),
    .rd_i        (data_rd),
    .rd_zero_i   (phase_i == '0),
    .rdata_o     (fifo_rdata_o),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .size_o      (xfer_size_o),
    .flags_o     (fifo_flags_o),
    .drop_o      (data_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    overrun_q <= 1'b0;
    else if (op == OP_FLUSH)        overrun_q <= 1'b0;
    else if (cmd_drop || data_drop) overrun_q <= 1'b1;
  end

  assign overrun_o = overrun_q;
endmodule

// File: rtl/cdfifo_checker.sv
module cdfifo_checker #(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int PHASE_W    = 3,
  localparam int PW = $clog2(DATA_DEPTH),
  localparam int SW = PW + 2,
  localparam int LW = $clog2(CMD_DEPTH + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fifo_wr_i,
  input logic                 fifo_rd_i,
  input logic                 cmd_collect_i,
  input logic [PHASE_W-1:0]   phase_i,
  input logic                 flush_i,
  input logic                 status_load_i,
  input logic [7:0]           fifo_rdata_o,
  input logic [PW-1:0]        fifo_flags_o,
  input logic signed [SW-1:0] xfer_size_o,
  input logic [LW-1:0]        cmd_len_o,
  input logic                 overrun_o,
  input logic [PW-1:0]        wr_ptr_i,
  input logic [PW-1:0]        rd_ptr_i
);
  localparam logic [PW-1:0] LAST = PW'(DATA_DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(CMD_DEPTH);

  logic quiet;
  assign quiet = !flush_i && !status_load_i;

  p_cmd_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_i && cmd_collect_i && quiet && cmd_len_o == FULL
    |=> $stable(cmd_len_o) && overrun_o);

  p_data_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_i && !cmd_collect_i && !fifo_rd_i && quiet && wr_ptr_i != LAST
    |=> xfer_size_o == $past(xfer_size_o) + SW'(1) && wr_ptr_i == $past(wr_ptr_i) + PW'(1));

  p_data_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_i && !cmd_collect_i && !fifo_rd_i && quiet && wr_ptr_i == LAST
    |=> overrun_o && wr_ptr_i == LAST);

  p_dataout_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i && phase_i == '0 && !fifo_wr_i && quiet
    |=> fifo_rdata_o == 8'h00 && $stable(rd_ptr_i) && $stable(xfer_size_o));

  p_ptr_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_i <= wr_ptr_i);

  p_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_load_i && !flush_i |=> fifo_flags_o == PW'(2) && xfer_size_o == SW'(2));

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cmd_len_o == '0 && !overrun_o && fifo_flags_o == '0 && xfer_size_o == '0);

  p_sticky_ovr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !flush_i |=> overrun_o);
endmodule

bind cdfifo_top cdfifo_checker #(
  .DATA_DEPTH (DATA_DEPTH),
  .CMD_DEPTH  (CMD_DEPTH),
  .PHASE_W    (PHASE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fifo_wr_i     (fifo_wr_i),
  .fifo_rd_i     (fifo_rd_i),
  .cmd_collect_i (cmd_collect_i),
  .phase_i       (phase_i),
  .flush_i       (flush_i),
  .status_load_i (status_load_i),
  .fifo_rdata_o  (fifo_rdata_o),
  .fifo_flags_o  (fifo_flags_o),
  .xfer_size_o   (xfer_size_o),
  .cmd_len_o     (cmd_len_o),
  .overrun_o     (overrun_o),
  .wr_ptr_i      (wr_ptr),
  .rd_ptr_i      (rd_ptr)
);

// File: tb/tb_cdfifo_top.sv
module tb_cdfifo_top;
  localparam int DD = 8;
  localparam int CD = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fifo_wr = 1'b0, fifo_rd = 1'b0, cmd_collect = 1'b0;
  logic              flush = 1'b0, status_load = 1'b0;
  logic [7:0]        fifo_wdata = '0, status_byte = '0;
  logic [2:0]        phase = '0;
  logic [1:0]        cmd_rd_addr = '0;
  logic [7:0]        fifo_rdata, cmd_rd_data;
  logic [2:0]        fifo_flags;
  logic signed [4:0] xfer_size;
  logic [2:0]        cmd_len;
  logic              overrun;

  int checks = 0;
  int errors = 0;

  int         m_wr, m_rd, m_size, m_clen;
  bit         m_ovr;
  logic [7:0] m_mem [DD];
  logic [7:0] m_cmd [CD];
  logic [7:0] m_rdata;

  always #5 clk = ~clk;

  cdfifo_top #(.DATA_DEPTH(DD), .CMD_DEPTH(CD), .PHASE_W(3)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .fifo_wr_i     (fifo_wr),
    .fifo_wdata_i  (fifo_wdata),
    .fifo_rd_i     (fifo_rd),
    .fifo_rdata_o  (fifo_rdata),
    .cmd_collect_i (cmd_collect),
    .phase_i       (phase),
    .flush_i       (flush),
    .status_load_i (status_load),
    .status_byte_i (status_byte),
    .fifo_flags_o  (fifo_flags),
    .xfer_size_o   (xfer_size),
    .cmd_len_o     (cmd_len),
    .cmd_rd_addr_i (cmd_rd_addr),
    .cmd_rd_data_o (cmd_rd_data),
    .overrun_o     (overrun)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, "/R13"}, "flags", int'(fifo_flags), m_wr - m_rd);
    chk(tag, "size", int'(xfer_size), m_size);
    chk(tag, "cmd_len", int'(cmd_len), m_clen);
    chk(tag, "overrun", int'(overrun), int'(m_ovr));
    chk(tag, "rdata", int'(fifo_rdata), int'(m_rdata));
  endtask

  // called at a falling edge; drives one cycle, updates the model, checks
  task automatic step(input bit w, input bit r, input bit cm, input logic [2:0] ph,
                      input bit fl, input bit sl, input logic [7:0] d,
                      input logic [7:0] st, input string tag);
    fifo_wr = w; fifo_rd = r; cmd_collect = cm; phase = ph;
    flush = fl; status_load = sl; fifo_wdata = d; status_byte = st;
    if (fl) begin
      m_wr = 0; m_rd = 0; m_size = 0; m_clen = 0; m_ovr = 0;
    end else if (sl) begin
      m_mem[0] = st; m_mem[1] = 8'h00; m_wr = 2; m_rd = 0; m_size = 2;
    end else begin
      if (w) begin
        if (cm) begin
          if (m_clen < CD) begin m_cmd[m_clen] = d; m_clen++; end
          else m_ovr = 1;
        end else if (m_wr == DD - 1) m_ovr = 1;
        else begin m_mem[m_wr] = d; m_wr++; m_size++; end
      end
      if (r) begin
        if (ph == 3'd0) m_rdata = 8'h00;
        else if (m_rd < m_wr) begin m_rdata = m_mem[m_rd]; m_rd++; m_size--; end
        if (m_rd == m_wr) begin m_rd = 0; m_wr = 0; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    fifo_wr = 0; fifo_rd = 0; flush = 0; status_load = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_wr = 0; m_rd = 0; m_size = 0; m_clen = 0; m_ovr = 0; m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");

    // every fill level, ordered drain, rewind
    for (int k = 1; k < DD; k++) begin
      for (int i = 0; i < k; i++)
        step(1, 0, 0, 3'd1, 0, 0, 8'((k * 13 + i * 29 + 7) & 8'hff), 8'h00, "R4");
      for (int i = 0; i < k; i++)
        step(0, 1, 0, 3'(1 + (k % 7)), 0, 0, 8'h00, 8'h00, "R7");
      chk("R9", "flags after drain", int'(fifo_flags), 0);
    end

    // overrun one entry before full, also after partial drain
    for (int i = 0; i < DD - 1; i++) step(1, 0, 0, 3'd1, 0, 0, 8'(8'h40 + i), 8'h00, "R4");
    step(1, 0, 0, 3'd1, 0, 0, 8'hEE, 8'h00, "R5");
    chk("R5", "overrun set", int'(overrun), 1);
    step(0, 1, 0, 3'd2, 0, 0, 8'h00, 8'h00, "R7");
    step(1, 0, 0, 3'd1, 0, 0, 8'hDD, 8'h00, "R5");
    for (int i = 0; i < DD - 2; i++) step(0, 1, 0, 3'd2, 0, 0, 8'h00, 8'h00, "R9");
    for (int i = 0; i < DD - 1; i++) step(1, 0, 0, 3'd1, 0, 0, 8'(8'h80 + i), 8'h00, "R9");
    chk("R12", "overrun kept", int'(overrun), 1);
    step(0, 0, 0, 3'd1, 1, 0, 8'h00, 8'h00, "R11");
    chk("R12", "overrun cleared by flush", int'(overrun), 0);

    // data-out read and empty read
    for (int i = 0; i < 3; i++) step(1, 0, 0, 3'd1, 0, 0, 8'(8'h11 * (i + 1)), 8'h00, "R4");
    step(0, 1, 0, 3'd0, 0, 0, 8'h00, 8'h00, "R6");
    chk("R6", "no pop", int'(fifo_flags), 3);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 3'd5, 0, 0, 8'h00, 8'h00, "R7");
    step(0, 1, 0, 3'd3, 0, 0, 8'h00, 8'h00, "R8");
    chk("R8", "rdata held", int'(fifo_rdata), 8'h33);

    // command collection beside held data
    step(1, 0, 0, 3'd1, 0, 0, 8'h5A, 8'h00, "R4");
    step(1, 0, 0, 3'd1, 0, 0, 8'h5B, 8'h00, "R4");
    for (int i = 0; i < CD; i++) step(1, 0, 1, 3'd1, 0, 0, 8'(8'hC0 + 3 * i), 8'h00, "R2");
    chk("R2", "data untouched", int'(fifo_flags), 2);
    step(1, 0, 1, 3'd1, 0, 0, 8'hFF, 8'h00, "R3");
    for (int i = 0; i < CD; i++) begin
      cmd_rd_addr = 2'(i);
      #1;
      chk("R2", "cmd byte", int'(cmd_rd_data), int'(m_cmd[i]));
    end
    step(0, 0, 0, 3'd1, 1, 0, 8'h00, 8'h00, "R11");

    // status response
    step(1, 0, 0, 3'd1, 0, 0, 8'h77, 8'h00, "R4");
    step(0, 0, 0, 3'd1, 0, 1, 8'h00, 8'hA5, "R10");
    step(0, 1, 0, 3'd4, 0, 0, 8'h00, 8'h00, "R10");
    chk("R10", "status byte", int'(fifo_rdata), 8'hA5);
    step(0, 1, 0, 3'd4, 0, 0, 8'h00, 8'h00, "R10");
    chk("R10", "pad byte", int'(fifo_rdata), 0);

    // priority
    step(1, 0, 0, 3'd1, 0, 0, 8'h21, 8'h00, "R4");
    step(1, 0, 0, 3'd1, 0, 1, 8'h99, 8'h3C, "R10");
    step(0, 1, 0, 3'd1, 0, 0, 8'h00, 8'h00, "R10");
    chk("R10", "status beat write", int'(fifo_rdata), 8'h3C);
    step(1, 1, 1, 3'd1, 1, 1, 8'h99, 8'h3C, "R11");
    chk("R11", "flush beat all", int'(cmd_len), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule